// File: doc/BRIEF.md
# Trace Overflow Queue

This block buffers trace messages from several producers (data trace, watchpoint hits and other trace kinds) on their way to a trace encoder. Each beat carries a message body of up to 109 bits, a length field and a type tag. Trace producers cannot stall, so the input is ready in almost every cycle. When a message arrives and the queue already holds its full depth, the queue stops storing. It keeps consuming and discarding every arrival, and it notes which kinds of message it threw away, until everything already queued has left.

When the queue is empty again it writes one fixed 15-bit error message whose code tells whether a watchpoint was among the lost messages. It raises a single-cycle overrun pulse in the same cycle, which the encoder can use to force its next data trace message into synchronised form. Normal queuing then resumes.

Both data interfaces are valid/ready. On the input, a beat is taken in any cycle where `in_valid` and `in_ready` are both high. `in_ready` drops only in the single cycle where the error message is written, and a producer holding `in_valid` is simply accepted one cycle later. On the output, `out_valid` stays high while the queue holds an entry, and the front entry stays stable until `out_ready` takes it.

Top module: `trace_ovf_queue`

## Requirements
- R1: Stored messages leave in arrival order with body and length unchanged; `out_valid` is high exactly when the queue holds an entry, and a held front entry stays stable until taken.
- R2: `in_ready` is high in every cycle except the error-write cycle; a beat offered while `in_ready` is low is neither stored nor counted as dropped.
- R3: An arrival that finds DEPTH entries queued (counted before any departure in that cycle) is not stored and starts drain mode.
- R4: In drain mode every arrival is consumed and discarded, and the queue gains no entries.
- R5: The error write happens in the first cycle where drain mode finds the queue empty; exactly one error message is written, then normal mode resumes.
- R6: The error code is 5'b01000 if any dropped message, including the one that triggered the overflow, had tag 2'b01 (watchpoint); otherwise it is 5'b00010. Tag 2'b00 is data trace, and 2'b10/2'b11 are other trace kinds.
- R7: The error message has bits [5:0] = 6'b001000, bits [9:6] = `src_id`, bits [14:10] = error code, all higher bits zero, and a length field of 15.
- R8: `overrun` is high for exactly one cycle, the error-write cycle, and at no other time.
- R9: During and right after reset, `out_valid` and `overrun` are low, `in_ready` is high, and drain mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_id | input | 4 | Source field placed in error messages |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_tag | input | 2 | Message type tag |
| in_data | input | 109 | Message body |
| in_len | input | 7 | Message length in bits |
| out_valid | output | 1 | Front entry available |
| out_ready | input | 1 | Consumer takes front entry |
| out_data | output | 109 | Front entry body |
| out_len | output | 7 | Front entry length |
| overrun | output | 1 | One-cycle pulse when the error message is written |

## Verification
The assertions assume that `src_id` is static while an error message sits in the queue, because the layout check compares the front entry against the live pin. The stimulus sets `src_id` once, before reset is released. No assumption is placed on the input handshake: producers may offer beats in any cycle, including the error-write cycle, so the stimulus keeps `in_valid` high through that cycle and mixes all four tag values in drain phases. The consumer side is driven both with long stalls, which fill the queue to the brim, and with random `out_ready`.

// File: rtl/trq_pkg.sv
package trq_pkg;
  localparam int TAG_W = 2;
  localparam int SRC_W = 4;
  localparam int CODE_W = 5;
  localparam int OP_W = 6;
  localparam int ERR_BITS = OP_W + SRC_W + CODE_W;

  localparam logic [TAG_W-1:0] TAG_DATA = 2'b00;
  localparam logic [TAG_W-1:0] TAG_WPT = 2'b01;

  localparam logic [OP_W-1:0] OP_ERROR = 6'b001000;
  localparam logic [CODE_W-1:0] CODE_DATA_ONLY = 5'b00010;
  localparam logic [CODE_W-1:0] CODE_WITH_WPT = 5'b01000;

  typedef enum logic {
    MODE_PASS,
    MODE_DRAIN
  } trq_mode_e;
endpackage

// File: rtl/trq_fifo.sv
module trq_fifo #(
  parameter int DEPTH = 8,
  parameter int WORD_W = 116,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  count
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      unique case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_word = mem[rd_ptr];
  assign count   = cnt_q;
endmodule

// File: rtl/trq_drain_ctl.sv
module trq_drain_ctl
  import trq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [CNT_W-1:0] count,
  output logic             in_ready,
  output logic             store_en,
  output logic             inject,
  output logic             drain_o,
  output logic             wp_seen
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  trq_mode_e mode_q;
  logic wp_q;
  logic accept, full, trigger, is_wpt;

  always_comb begin
    full     = (count == FULL_CNT);
    inject   = (mode_q == MODE_DRAIN) && (count == '0);
    in_ready = !inject;
    accept   = in_valid && in_ready;
    is_wpt   = (in_tag == TAG_WPT);
    store_en = accept && (mode_q == MODE_PASS) && !full;
    trigger  = accept && (mode_q == MODE_PASS) && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PASS;
      wp_q   <= 1'b0;
    end else if (inject) begin
      mode_q <= MODE_PASS;
      wp_q   <= 1'b0;
    end else if (trigger) begin
      mode_q <= MODE_DRAIN;
      wp_q   <= is_wpt;
    end else if (accept && mode_q == MODE_DRAIN) begin
      wp_q   <= wp_q | is_wpt;
    end
  end

  assign drain_o = (mode_q == MODE_DRAIN);
  assign wp_seen = wp_q;
endmodule

// File: rtl/trq_errfmt.sv
module trq_errfmt
  import trq_pkg::*;
#(
  parameter int DATA_W = 109,
  parameter int LEN_W = 7
) (
  input  logic [SRC_W-1:0]  src_id,
  input  logic              wp_seen,
  output logic [DATA_W-1:0] err_data,
  output logic [LEN_W-1:0]  err_len
);
  logic [CODE_W-1:0] code;

  always_comb begin
    code = wp_seen ? CODE_WITH_WPT : CODE_DATA_ONLY;
    err_data = '0;
    err_data[OP_W-1:0] = OP_ERROR;
    err_data[OP_W+SRC_W-1:OP_W] = src_id;
    err_data[ERR_BITS-1:OP_W+SRC_W] = code;
    err_len = LEN_W'(ERR_BITS);
  end
endmodule

// File: rtl/trace_ovf_queue.sv
module trace_ovf_queue
  import trq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DATA_W = 109,
  parameter int LEN_W = 7,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WORD_W = DATA_W + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_id,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LEN_W-1:0]  out_len,
  output logic              overrun
);
  logic [CNT_W-1:0]  fill_cnt;
  logic              store_en, inject, drain_q, wp_seen;
  logic [DATA_W-1:0] err_data;
  logic [LEN_W-1:0]  err_len;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              wr_en, rd_en;

  trq_drain_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .count(fill_cnt), .in_ready(in_ready), .store_en(store_en),
    .inject(inject), .drain_o(drain_q), .wp_seen(wp_seen)
  );

  trq_errfmt #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fmt (
    .src_id(src_id), .wp_seen(wp_seen), .err_data(err_data), .err_len(err_len)
  );

  always_comb begin
    wr_en   = store_en | inject;
    wr_word = inject ? {err_len, err_data} : {in_len, in_data};
  end

  assign out_valid = (fill_cnt != '0);
  assign rd_en     = out_valid && out_ready;

  trq_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .rd_en(rd_en), .rd_word(rd_word), .count(fill_cnt)
  );

  assign out_data = rd_word[DATA_W-1:0];
  assign out_len  = rd_word[WORD_W-1:DATA_W];
  assign overrun  = inject;
endmodule

// File: rtl/trq_checker.sv
module trq_checker
  import trq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DATA_W = 109,
  parameter int LEN_W = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_W-1:0]  src_id,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [LEN_W-1:0]  out_len,
  input logic              overrun,
  input logic [CNT_W-1:0]  count,
  input logic              drain
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  AST_FRONT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len)); // R1
  AST_READY_ONLY_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> overrun); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R3
  AST_DRAIN_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    drain && !overrun |=> count <= $past(count)); // R4
  AST_INJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !out_valid && drain); // R5
  AST_INJECT_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !drain); // R5
  AST_ERR_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> out_valid && out_len == LEN_W'(ERR_BITS)
      && out_data[OP_W-1:0] == OP_ERROR
      && out_data[OP_W+SRC_W-1:OP_W] == src_id
      && out_data[DATA_W-1:ERR_BITS] == '0); // R7
  AST_ERR_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> out_data[ERR_BITS-1:OP_W+SRC_W] == CODE_DATA_ONLY
      || out_data[ERR_BITS-1:OP_W+SRC_W] == CODE_WITH_WPT); // R6
  AST_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun); // R8
  AST_OVERRUN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !in_ready); // R8
endmodule

bind trace_ovf_queue trq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_trq_chk (
  .clk(clk), .rst_n(rst_n), .src_id(src_id), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_len(out_len), .overrun(overrun), .count(fill_cnt), .drain(drain_q)
);

// File: tb/test_trace_ovf_queue.sv
`timescale 1ns/1ps
module test_trace_ovf_queue;
  localparam int DEPTH = 8;
  localparam int DW = 109;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_id = 4'hA;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_tag = 2'b00;
  logic [DW-1:0] in_data = '0;
  logic [LW-1:0] in_len = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [LW-1:0] out_len;
  logic overrun;

  int checks = 0;
  int errors = 0;
  int ovr_cnt = 0;
  int err_seen = 0;
  logic [DW-1:0] last_err = '0;

  logic [LW+DW-1:0] mq[$];
  bit m_drain = 0;
  bit m_wp = 0;

  always #2 clk = ~clk;

  trace_ovf_queue i_trace_ovf_queue (
    .clk(clk), .rst_n(rst_n), .src_id(src_id), .in_valid(in_valid),
    .in_ready(in_ready), .in_tag(in_tag), .in_data(in_data), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_len(out_len), .overrun(overrun)
  );

  function automatic logic [DW-1:0] err_word(input bit wp);
    logic [DW-1:0] w = '0;
    w[5:0] = 6'b001000;
    w[9:6] = src_id;
    w[14:10] = wp ? 5'b01000 : 5'b00010;
    return w;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, stepped on each rising edge
  always @(posedge clk) begin
    int sz;
    bit inj, pop;
    if (!rst_n) begin
      mq.delete();
      m_drain = 0;
      m_wp = 0;
    end else begin
      sz = mq.size();
      inj = m_drain && sz == 0;
      pop = sz != 0 && out_ready;
      if (pop) void'(mq.pop_front());
      if (inj) begin
        mq.push_back({LW'(15), err_word(m_wp)});
        m_drain = 0;
        m_wp = 0;
      end else if (in_valid) begin
        if (m_drain) m_wp = m_wp | (in_tag == 2'b01);
        else if (sz == DEPTH) begin
          m_drain = 1;
          m_wp = (in_tag == 2'b01);
        end else mq.push_back({in_len, in_data});
      end
    end
  end

  // error message capture at the output handshake
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && out_len == LW'(15) && out_data[5:0] == 6'b001000) begin
      err_seen++;
      last_err = out_data;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "in_ready", 128'(in_ready), 128'(!(m_drain && mq.size() == 0)));
      chk("R8", "overrun", 128'(overrun), 128'(m_drain && mq.size() == 0));
      chk("R1", "out_valid", 128'(out_valid), 128'(mq.size() != 0));
      if (mq.size() != 0) begin
        chk("R1 R3 R4 R5 R7", "out_data", 128'(out_data), 128'(mq[0][DW-1:0]));
        chk("R1 R7", "out_len", 128'(out_len), 128'(mq[0][LW+DW-1:DW]));
      end
      if (overrun) ovr_cnt++;
    end
  end

  task automatic cyc(input bit v, input logic [1:0] tg, input bit rdy, input int len);
    logic [127:0] r = {$urandom(), $urandom(), $urandom(), $urandom()};
    in_valid = v;
    in_tag = tg;
    in_data = r[DW-1:0];
    in_data[5:0] = 6'b111111;
    in_len = LW'(len);
    out_ready = rdy;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "out_valid in reset", 128'(out_valid), 128'(0));
    chk("R9", "in_ready in reset", 128'(in_ready), 128'(1));
    chk("R9", "overrun in reset", 128'(overrun), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "out_valid after reset", 128'(out_valid), 128'(0));

    // R1 streaming with a free consumer
    for (int i = 0; i < 20; i++) cyc(1, 2'b00, 1, 100);
    cyc(0, 2'b00, 1, 100);
    cyc(0, 2'b00, 1, 100);

    // R3 R4 R6 overflow with only data trace and other kinds dropped
    for (int i = 0; i < DEPTH; i++) cyc(1, 2'b00, 0, 90);
    cyc(1, 2'b00, 0, 90);
    cyc(1, 2'b10, 0, 90);
    cyc(1, 2'b11, 0, 90);
    for (int i = 0; i < DEPTH + 6; i++) cyc(1, 2'b00, 1, 90);
    cyc(0, 2'b00, 1, 90);
    chk("R8", "overrun pulses after first drain", 128'(ovr_cnt), 128'(1));
    chk("R6", "code without watchpoint", 128'(last_err[14:10]), 128'(5'b00010));
    chk("R7", "error word layout", 128'(last_err), 128'(err_word(0)));

    // R6 watchpoint among the discarded messages
    for (int i = 0; i < DEPTH; i++) cyc(1, 2'b00, 0, 80);
    cyc(1, 2'b00, 0, 80);
    cyc(1, 2'b01, 0, 80);
    for (int i = 0; i < DEPTH + 6; i++) cyc(1, 2'b00, 1, 80);
    cyc(0, 2'b00, 1, 80);
    chk("R6", "code with watchpoint", 128'(last_err[14:10]), 128'(5'b01000));

    // R6 the triggering message alone is a watchpoint
    for (int i = 0; i < DEPTH; i++) cyc(1, 2'b00, 0, 70);
    cyc(1, 2'b01, 0, 70);
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, 2'b00, 1, 70);
    chk("R6", "code from trigger watchpoint", 128'(last_err[14:10]), 128'(5'b01000));
    chk("R5", "one error per overrun", 128'(err_seen), 128'(ovr_cnt));
    chk("R8", "overrun pulses total", 128'(ovr_cnt), 128'(3));

    // random traffic, R1 through R8 against the model
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
          $urandom_range(0, 2) == 0, $urandom_range(1, 109));
    for (int i = 0; i < 3 * DEPTH; i++) cyc(0, 2'b00, 1, 50);
    chk("R5", "one error per overrun in random phase", 128'(err_seen), 128'(ovr_cnt));
    chk("R1", "queue empty at end", 128'(out_valid), 128'(0));
    finish_run();
  end
endmodule